// File: doc/BRIEF.md
# TPM FIFO Command Transmit Sequencer

This block sits on the host side of a TPM-style FIFO register interface. It pushes one command into that interface and then starts its execution. A start strobe with a byte count begins the operation. The command bytes then arrive on a valid/ready byte stream. The block drives a simple memory-mapped master port made of address, read strobe, write strobe, 32-bit write and read data, and a ready handshake. Through that port it polls the status register and writes the data FIFO register.

Flow control comes only from the status word. The block waits for the device to report command-ready. It then feeds bytes in bursts no longer than the burst count the device advertises, keeping the final byte back. After each burst it confirms that the device still expects more data. It writes the final byte on its own, confirms that the expect flag has dropped, and writes the go code to the status register. Every wait is bounded by a poll budget. The outcome is a one-cycle done pulse with a 2-bit result code: 0 for success, 1 for timeout, 2 for protocol error. The code is held until the next start.

Top module: `tpm_cmd_sender`

## Requirements
- R1: After reset the block is idle: busy, done, in_ready, bus_rd and bus_wr are low and result is 0.
- R2: A start with cmd_len equal to 0 produces done with result 2 one cycle later, and no bus transfer takes place.
- R3: Every bus read targets the status address STS_ADDR. The first wait repeats status reads until bit 6 (command ready) is set, and bits of the status word outside the named fields have no effect.
- R4: The burst count is status bits [23:8]. Whenever the burst count is zero and more bytes are due, the block polls the status register until the count is nonzero.
- R5: Each burst writes min(burst count, remaining bytes − 1) bytes, in stream order, to FIFO_ADDR. Each byte is placed in bits [7:0] and the upper bits are zero.
- R6: After each burst the block polls until status bit 7 (valid) is set. If bit 3 (expect) is then clear, the operation ends with result 2 and no further writes.
- R7: The final byte is written alone. This happens only after a valid status read shows exactly one byte left and a nonzero burst count. A one-byte command therefore writes no burst bytes first.
- R8: After the final byte the block polls until valid is set. If expect is still set, the result is 2. Otherwise the block writes 0x00000020 to STS_ADDR and ends with result 0.
- R9: Each wait gives up after MAX_POLLS unsatisfied status reads, spaced TICK_CYCLES idle cycles apart, and ends with result 1.
- R10: A bus strobe stays high, with stable address and write data, until a cycle with bus_ready high. bus_rd and bus_wr are never high together.
- R11: done is a single-cycle pulse. result keeps its value while idle until the next start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin sending a command (taken when idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| in_data | input | 8 | Command byte stream data |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Block takes a byte this cycle when in_valid is high |
| bus_addr | output | ADDR_W | Register address |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Transfer completes this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 timeout, 2 protocol error |

## Verification
The checker watches every cycle for the bus handshake rules: strobes held stable until ready and never both high at once. It also checks that every read targets the status address, that FIFO writes carry a single byte, that the only status write is the go code, and that the zero-length reply, the done pulse and the held result behave as required. The ordering questions can only be shown by the bench's scenarios, which run against a behavioural model of the feed algorithm and scripted status words. These cover how many bytes each burst carries, when the final byte is released, how a zero burst count or a missing valid flag leads to more polls, and which expect-flag state ends the operation with which code.

// File: rtl/tpm_cmd_sender.sv
module tpm_cmd_sender #(
  parameter int ADDR_W      = 12,
  parameter int LEN_W       = 16,
  parameter int TICK_CYCLES = 100,
  parameter int MAX_POLLS   = 1000000,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 12'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 12'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int CW = (LEN_W > 16) ? LEN_W : 16;
  localparam logic [1:0] RES_OK = 2'd0, RES_TMO = 2'd1, RES_PROTO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_GAP, S_FETCH, S_WR, S_GO} st_t;
  typedef enum logic [1:0] {W_RDY, W_BURST, W_VALID, W_LAST} wk_t;

  st_t            st;
  wk_t            wk;
  logic [LEN_W-1:0] rem;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  gap;
  logic [PW-1:0]  polls;
  logic           last;
  logic           met;

  wire [15:0]   bc     = bus_rdata[23:8];
  wire [CW-1:0] bc_x   = CW'(bc);
  wire [CW-1:0] rem_m1 = CW'(rem) - CW'(1);
  wire [CW-1:0] chunk  = (bc_x < rem_m1) ? bc_x : rem_m1;

  assign in_ready = (st == S_FETCH);
  assign busy     = (st != S_IDLE);

  always_comb begin
    case (wk)
      W_RDY:   met = bus_rdata[6];
      W_BURST: met = (bc != 16'd0);
      default: met = bus_rdata[7];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wk <= W_RDY; rem <= '0; cnt <= '0; gap <= '0; polls <= '0;
      last <= 1'b0; bus_addr <= '0; bus_rd <= 1'b0; bus_wr <= 1'b0;
      bus_wdata <= '0; done <= 1'b0; result <= RES_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          result <= RES_OK;
          if (cmd_len == '0) begin
            done <= 1'b1; result <= RES_PROTO;
          end else begin
            rem <= cmd_len; last <= 1'b0; wk <= W_RDY; polls <= '0;
            bus_rd <= 1'b1; bus_addr <= STS_ADDR; st <= S_RD;
          end
        end
        S_GAP: begin
          if (gap == '0) begin
            bus_rd <= 1'b1; bus_addr <= STS_ADDR; st <= S_RD;
          end else gap <= gap - TW'(1);
        end
        S_RD: if (bus_ready) begin
          bus_rd <= 1'b0;
          if (!met) begin
            if (polls == PW'(MAX_POLLS - 1)) begin
              done <= 1'b1; result <= RES_TMO; st <= S_IDLE;
            end else begin
              polls <= polls + PW'(1); gap <= TW'(TICK_CYCLES - 1); st <= S_GAP;
            end
          end else if (wk == W_LAST) begin
            if (bus_rdata[3]) begin
              done <= 1'b1; result <= RES_PROTO; st <= S_IDLE;
            end else begin
              bus_wr <= 1'b1; bus_addr <= STS_ADDR; bus_wdata <= 32'h20; st <= S_GO;
            end
          end else if (wk == W_VALID && !bus_rdata[3]) begin
            done <= 1'b1; result <= RES_PROTO; st <= S_IDLE;
          end else if (wk != W_BURST && bc == 16'd0) begin
            wk <= W_BURST; polls <= '0; gap <= TW'(TICK_CYCLES - 1); st <= S_GAP;
          end else if (wk == W_VALID && rem == LEN_W'(1)) begin
            last <= 1'b1; st <= S_FETCH;
          end else if (chunk == '0) begin
            wk <= W_VALID; polls <= '0; bus_rd <= 1'b1; bus_addr <= STS_ADDR; st <= S_RD;
          end else begin
            cnt <= chunk; st <= S_FETCH;
          end
        end
        S_FETCH: if (in_valid) begin
          bus_wr <= 1'b1; bus_addr <= FIFO_ADDR; bus_wdata <= {24'h0, in_data}; st <= S_WR;
        end
        S_WR: if (bus_ready) begin
          bus_wr <= 1'b0;
          rem <= rem - LEN_W'(1);
          if (last || cnt == CW'(1)) begin
            wk <= last ? W_LAST : W_VALID; polls <= '0;
            bus_rd <= 1'b1; bus_addr <= STS_ADDR; st <= S_RD;
          end else begin
            cnt <= cnt - CW'(1); st <= S_FETCH;
          end
        end
        S_GO: if (bus_ready) begin
          bus_wr <= 1'b0; done <= 1'b1; result <= RES_OK; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpm_cmd_sender_chk.sv
module tpm_cmd_sender_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 16,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 12'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 12'h024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              in_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic              bus_ready,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr)); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R10
  AST_RD_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_addr == STS_ADDR); // R3
  AST_FIFO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == FIFO_ADDR |-> bus_wdata[31:8] == 24'h0); // R5
  AST_GO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == STS_ADDR |-> bus_wdata == 32'h20); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && cmd_len == '0 |=> done && result == 2'd2 && !bus_rd && !bus_wr); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_rd && !bus_wr && !in_ready); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result)); // R11
endmodule

bind tpm_cmd_sender tpm_cmd_sender_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STS_ADDR(STS_ADDR), .FIFO_ADDR(FIFO_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .in_ready(in_ready),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready), .busy(busy), .done(done), .result(result)
);

// File: tb/tpm_cmd_sender_tb_top.sv
module tpm_cmd_sender_tb_top;
  localparam int TICK = 3;
  localparam int MAXP = 6;
  localparam logic [11:0] STS  = 12'h018;
  localparam logic [11:0] FIFO = 12'h024;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] cmd_len = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  wire         in_ready, bus_wr, bus_rd, busy, done;
  wire [11:0]  bus_addr;
  wire [31:0]  bus_wdata;
  wire [1:0]   result;

  always #5 clk = ~clk;

  tpm_cmd_sender #(.TICK_CYCLES(TICK), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done), .result(result));

  int checks = 0, errors = 0;
  logic [31:0] sts_script[$];
  logic [7:0]  bytes[$];
  logic [44:0] exp_q[$];
  logic [44:0] cap, e;
  logic [1:0]  exp_res;
  int sts_idx = 0, byte_idx = 0, stall_n = 0, stall_cnt = 0, gap_mod = 0, cyc = 0;
  bit hs_pend = 0, cons_pend = 0, waiting = 0;
  logic [11:0] wait_addr;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_sts(inout int si);
    logic [31:0] v = sts_script[si];
    if (si < sts_script.size() - 1) si++;
    exp_q.push_back({1'b0, STS, 32'h0});
    return v;
  endfunction

  function automatic bit poll(input int mode, inout int si, output logic [31:0] v);
    for (int n = 0; n < MAXP; n++) begin
      v = next_sts(si);
      if (mode == 0 && v[6]) return 1'b1;
      if (mode == 1 && v[23:8] != 16'd0) return 1'b1;
      if (mode == 2 && v[7]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic predict(int len);
    int si, off, b, c;
    logic [31:0] v;
    si = 0; off = 0;
    exp_q.delete();
    if (len == 0) begin exp_res = 2; return; end
    if (!poll(0, si, v)) begin exp_res = 1; return; end
    b = int'(v[23:8]);
    forever begin
      if (b == 0) begin
        if (!poll(1, si, v)) begin exp_res = 1; return; end
        b = int'(v[23:8]);
      end
      c = (b < len - off - 1) ? b : len - off - 1;
      for (int k = 0; k < c; k++) begin
        exp_q.push_back({1'b1, FIFO, 24'h0, bytes[off]});
        off++;
      end
      if (!poll(2, si, v)) begin exp_res = 1; return; end
      if (!v[3]) begin exp_res = 2; return; end
      b = int'(v[23:8]);
      if (off == len - 1 && b != 0) break;
    end
    exp_q.push_back({1'b1, FIFO, 24'h0, bytes[off]});
    if (!poll(2, si, v)) begin exp_res = 1; return; end
    if (v[3]) begin exp_res = 2; return; end
    exp_q.push_back({1'b1, STS, 32'h20});
    exp_res = 0;
  endtask

  // Device model and transfer monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (hs_pend) begin
      hs_pend = 0;
      if (exp_q.size() == 0) check(1'b0, "R5", "unexpected bus transfer", 64'(cap), 64'h0);
      else begin
        e = exp_q.pop_front();
        if (!e[44]) check(cap == e, "R6", "status read order", 64'(cap), 64'(e));
        else if (e[43:32] == FIFO) check(cap == e, "R5", "byte write", 64'(cap), 64'(e));
        else check(cap == e, "R8", "go write", 64'(cap), 64'(e));
      end
      if (!cap[44] && sts_idx < sts_script.size() - 1) sts_idx++;
    end
    if (waiting) check((bus_rd || bus_wr) && bus_addr == wait_addr, "R10", "strobe held",
                       64'(bus_addr), 64'(wait_addr));
    waiting = 0;
    if (bus_rd || bus_wr) begin
      if (stall_cnt < stall_n) begin
        stall_cnt++; bus_ready = 1'b0; waiting = 1; wait_addr = bus_addr;
      end else begin
        stall_cnt = 0; bus_ready = 1'b1;
        bus_rdata = (sts_script.size() > 0) ? sts_script[sts_idx] : 32'h0;
        cap = {bus_wr, bus_addr, bus_rd ? 32'h0 : bus_wdata};
        hs_pend = 1;
      end
    end else bus_ready = 1'b0;
    if (cons_pend) begin byte_idx++; cons_pend = 0; end
    in_valid = (byte_idx < bytes.size()) && (gap_mod == 0 || (cyc % gap_mod) != 0);
    in_data  = (byte_idx < bytes.size()) ? bytes[byte_idx] : 8'h00;
    if (in_valid && in_ready) cons_pend = 1;
  end

  task automatic run(string req, int len, int stall, int gmod);
    int n;
    logic [1:0] held;
    cmd_len = 16'(len); stall_n = stall; gap_mod = gmod;
    sts_idx = 0; byte_idx = 0; stall_cnt = 0;
    predict(len);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(n < 5000, req, "completion seen", 64'(n), 64'd5000);
    check(result == exp_res, req, "result code", 64'(result), 64'(exp_res));
    held = result;
    @(negedge clk);
    check(!done, "R11", "done single pulse", 64'(done), 64'h0);
    check(exp_q.size() == 0, req, "transfers left over", 64'(exp_q.size()), 64'h0);
    repeat (3) @(negedge clk);
    check(result == held && !busy, "R11", "result held while idle", 64'(result), 64'(held));
  endtask

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !bus_rd && !bus_wr && !in_ready && result == 2'd0, "R1",
          "reset state", {busy, done, bus_rd, bus_wr, in_ready, result}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: empty command
    sts_script = {32'h0000_0240}; bytes = {};
    run("R2", 0, 0, 0);

    // R5: two bursts of two bytes, stalled bus, gappy stream
    sts_script = {32'h0000_0240, 32'h0000_0288, 32'h0000_0288, 32'h0000_0080};
    bytes = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    run("R5", 5, 1, 3);

    // R4: zero burst count after ready, re-poll
    sts_script = {32'h0000_0040, 32'h0000_0000, 32'h0000_0300, 32'h0000_0188, 32'h0000_0080};
    bytes = {8'hA1, 8'hB2, 8'hC3};
    run("R4", 3, 2, 0);

    // R7: one-byte command
    sts_script = {32'h0000_0140, 32'h0000_0088, 32'h0000_0188, 32'h0000_0188, 32'h0000_0080};
    bytes = {8'h5A};
    run("R7", 1, 0, 0);

    // R6: expect dropped after a burst
    sts_script = {32'h0000_0A40, 32'h0000_0080};
    bytes = {8'h01, 8'h02, 8'h03, 8'h04};
    run("R6", 4, 0, 2);

    // R8: expect still set after the final byte
    sts_script = {32'h0000_0140, 32'h0000_0188, 32'h0000_0188};
    bytes = {8'h7E, 8'h7F};
    run("R8", 2, 1, 0);

    // R9: command ready never seen
    sts_script = {32'h0000_0000};
    bytes = {8'h99};
    run("R9", 1, 0, 0);

    // R9: valid never seen after a burst
    sts_script = {32'h0000_0240, 32'h0000_0008};
    bytes = {8'hE0, 8'hE1};
    run("R9", 2, 1, 0);

    // R3: ready missing at first, unrelated high bits set, wide burst
    sts_script = {32'h0000_1000, 32'hF000_1040, 32'h0000_1088, 32'h0000_0080};
    bytes = {8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80};
    run("R3", 8, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule